// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Status Flags

This block is the data-path arithmetic and logic unit of a small 16-bit processor core. Each cycle it takes a source operand, a destination operand, a 4-bit operation code, a byte/word select and an incoming carry. It produces a combinational result together with a result-write strobe. The carry, zero, negative and overflow flags it derives are held in a flag register, which loads only when the execute strobe is high.

Every operation exists in a word form and a byte form. In byte form only the low eight bits of each operand take part, and the flags come from bit 7 rather than bit 15. The operations are binary add and subtract, each with or without the incoming carry, compare, four bitwise operations, bit test, move, and a packed-decimal add with carry. Compare and bit test affect only the flags. Move, bit-clear and bit-set affect only the result.

Top module: `alu_flags_unit`

## Requirements
- R1: Operation codes: 0x0 move (result = source), 0x8 bit-clear (destination AND NOT source), 0x9 bit-set (destination OR source), 0xA exclusive-or, 0xB AND.
- R2: Codes 0x1 add and 0x2 add-with-carry give destination + source (+ carry_i for 0x2). C is the carry out of the selected width.
- R3: Codes 0x3 subtract, 0x4 subtract-with-carry and 0x5 compare give destination + NOT source + 1, with carry_i used in place of the 1 for 0x4. C set means no borrow.
- R4: For additions V is set when two operands of equal sign give a result of the other sign. For subtraction and compare V is set for positive minus negative giving negative, and for negative minus positive giving positive.
- R5: N equals bit 15 of the result in word mode and bit 7 in byte mode. Z is set exactly when the selected width of the result is zero.
- R6: In byte mode (byte_i = 1), result bits 15..8 are zero and operand bits 15..8 have no effect.
- R7: res_we_o is low for compare (0x5), for bit test (0x7) and for the unused codes 0xC to 0xF. The unused codes also leave the flags unchanged. res_we_o is high for every other code.
- R8: AND (0xB) and bit test (0x7, result destination AND source) set C to NOT Z and clear V. Exclusive-or sets C to NOT Z and sets V only when both operands are negative in the selected width.
- R9: Move, bit-clear and bit-set leave all four flags unchanged.
- R10: Code 0x6 is a packed-decimal add of destination, source and carry_i. C is the decimal carry out of the top digit of the selected width, and V is cleared.
- R11: The flags load on a rising clock edge only while exec_i is high. An active-low reset clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe; enables the flag update |
| opcode_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| carry_i | input | 1 | Incoming carry |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| result_o | output | 16 | Result, combinational |
| res_we_o | output | 1 | Result should be written back |
| flag_c_o | output | 1 | Carry flag |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
The bench targets width selection. A byte add whose carry leaves bit 7 must set C and Z. A design that took the carry out of bit 15 would miss both flags, and one that let operand bits 15..8 through would produce a non-zero upper byte. It checks V at the 0x7FFF/0x8000 and 0x7F/0x80 edges for both add and subtract. Applying the addition sign rule to subtraction would invert V in those cases. It checks decimal adds that carry through several digits, and bit test and compare running after a move, so that a unit that writes flags for move, or asserts the write strobe for compare, shows a wrong flag or strobe value.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [3:0] {
      OP_MOV  = 4'h0,
      OP_ADD  = 4'h1,
      OP_ADDC = 4'h2,
      OP_SUB  = 4'h3,
      OP_SUBC = 4'h4,
      OP_CMP  = 4'h5,
      OP_DADD = 4'h6,
      OP_BIT  = 4'h7,
      OP_BIC  = 4'h8,
      OP_BIS  = 4'h9,
      OP_XOR  = 4'hA,
      OP_AND  = 4'hB,
      OP_RSVC = 4'hC,
      OP_RSVD = 4'hD,
      OP_RSVE = 4'hE,
      OP_RSVF = 4'hF
   } alu_op_e;

   typedef enum logic [1:0] {
      LG_MOV = 2'd0,
      LG_AND = 2'd1,
      LG_BIC = 2'd2,
      LG_BIS = 2'd3
   } logic_sel_e;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
   } alu_flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
   parameter int DATA_W     = 16,
   parameter int BYTE_W     = 8,
   parameter bit DECIMAL_EN = 1'b1
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic              byte_i,
   input  logic              sub_i,
   input  logic              use_cin_i,
   input  logic              dec_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] res_o,
   output logic              c_o,
   output logic              v_o
);
   localparam int NDIG   = DATA_W / 4;
   localparam int BDIG   = BYTE_W / 4;
   localparam int UPPER  = DATA_W - BYTE_W;

   logic [DATA_W-1:0] opx;
   logic              cin;
   logic [DATA_W:0]   sum_w;
   logic [BYTE_W:0]   sum_b;
   logic [DATA_W-1:0] bin_res;
   logic              bin_c;
   logic              bin_v;
   logic [DATA_W-1:0] dec_sum;
   logic [NDIG:0]     dec_c;
   logic              sgn_d;
   logic              sgn_s;
   logic              sgn_r;

   assign opx   = sub_i ? ~src_i : src_i;
   assign cin   = use_cin_i ? carry_i : sub_i;
   assign sum_w = {1'b0, dst_i} + {1'b0, opx} + {{DATA_W{1'b0}}, cin};
   assign sum_b = {1'b0, dst_i[BYTE_W-1:0]} + {1'b0, opx[BYTE_W-1:0]}
                + {{BYTE_W{1'b0}}, cin};

   always_comb begin
      if (byte_i) begin
         bin_res = {{UPPER{1'b0}}, sum_b[BYTE_W-1:0]};
         bin_c   = sum_b[BYTE_W];
         sgn_d   = dst_i[BYTE_W-1];
         sgn_s   = opx[BYTE_W-1];
         sgn_r   = sum_b[BYTE_W-1];
      end else begin
         bin_res = sum_w[DATA_W-1:0];
         bin_c   = sum_w[DATA_W];
         sgn_d   = dst_i[DATA_W-1];
         sgn_s   = opx[DATA_W-1];
         sgn_r   = sum_w[DATA_W-1];
      end
      bin_v = (sgn_d == sgn_s) && (sgn_r != sgn_d);
   end

   assign dec_c[0] = carry_i;

   generate
      if (DECIMAL_EN) begin : g_dec
         for (genvar k = 0; k < NDIG; k++) begin : g_digit
            logic [4:0] raw;
            assign raw          = {1'b0, dst_i[4*k +: 4]} + {1'b0, src_i[4*k +: 4]}
                                + {4'd0, dec_c[k]};
            assign dec_c[k+1]   = (raw > 5'd9);
            assign dec_sum[4*k +: 4] = dec_c[k+1] ? (raw[3:0] + 4'd6) : raw[3:0];
         end
      end else begin : g_nodec
         assign dec_c[NDIG:1] = '0;
         assign dec_sum       = '0;
      end
   endgenerate

   always_comb begin
      if (dec_i) begin
         res_o = byte_i ? {{UPPER{1'b0}}, dec_sum[BYTE_W-1:0]} : dec_sum;
         c_o   = byte_i ? dec_c[BDIG] : dec_c[NDIG];
         v_o   = 1'b0;
      end else begin
         res_o = bin_res;
         c_o   = bin_c;
         v_o   = bin_v;
      end
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   input  logic_sel_e        sel_i,
   input  logic              xor_i,
   output logic [DATA_W-1:0] res_o
);
   always_comb begin
      if (xor_i) begin
         res_o = dst_i ^ src_i;
      end else begin
         unique case (sel_i)
            LG_MOV:  res_o = src_i;
            LG_AND:  res_o = dst_i & src_i;
            LG_BIC:  res_o = dst_i & ~src_i;
            LG_BIS:  res_o = dst_i | src_i;
            default: res_o = src_i;
         endcase
      end
   end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_i,
   input  alu_flags_t d_i,
   output alu_flags_t q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (we_i) begin
         q_o <= d_i;
      end
   end

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o)) else $error("flags moved without write"); // R11
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
   import alu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int BYTE_W     = 8,
   parameter bit DECIMAL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_i,
   input  logic [3:0]        opcode_i,
   input  logic              byte_i,
   input  logic              carry_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] dst_i,
   output logic [DATA_W-1:0] result_o,
   output logic              res_we_o,
   output logic              flag_c_o,
   output logic              flag_z_o,
   output logic              flag_n_o,
   output logic              flag_v_o
);
   localparam int UPPER = DATA_W - BYTE_W;

   generate
      if (DATA_W != 2 * BYTE_W) begin : g_bad_width
         $error("DATA_W must be twice BYTE_W");
      end
      if ((BYTE_W % 4) != 0) begin : g_bad_digit
         $error("BYTE_W must be a whole number of decimal digits");
      end
   endgenerate

   alu_op_e     op;
   logic        is_arith;
   logic        is_sub;
   logic        use_cin;
   logic        is_dec;
   logic        is_xor;
   logic_sel_e  lsel;
   logic        flag_we;
   logic        logic_cv;
   logic [DATA_W-1:0] src_m;
   logic [DATA_W-1:0] dst_m;
   logic [DATA_W-1:0] ar_res;
   logic [DATA_W-1:0] lg_res;
   logic        ar_c;
   logic        ar_v;
   logic        sgn_both;
   alu_flags_t  f_next;
   alu_flags_t  f_q;

   assign op = alu_op_e'(opcode_i);

   always_comb begin
      is_arith = 1'b0;
      is_sub   = 1'b0;
      use_cin  = 1'b0;
      is_dec   = 1'b0;
      is_xor   = 1'b0;
      lsel     = LG_MOV;
      res_we_o = 1'b1;
      flag_we  = 1'b0;
      logic_cv = 1'b0;
      unique case (op)
         OP_MOV:  lsel = LG_MOV;
         OP_ADD:  begin is_arith = 1'b1; flag_we = 1'b1; end
         OP_ADDC: begin is_arith = 1'b1; use_cin = 1'b1; flag_we = 1'b1; end
         OP_SUB:  begin is_arith = 1'b1; is_sub = 1'b1; flag_we = 1'b1; end
         OP_SUBC: begin is_arith = 1'b1; is_sub = 1'b1; use_cin = 1'b1; flag_we = 1'b1; end
         OP_CMP:  begin is_arith = 1'b1; is_sub = 1'b1; flag_we = 1'b1; res_we_o = 1'b0; end
         OP_DADD: begin is_arith = 1'b1; is_dec = 1'b1; flag_we = 1'b1; end
         OP_BIT:  begin lsel = LG_AND; logic_cv = 1'b1; flag_we = 1'b1; res_we_o = 1'b0; end
         OP_BIC:  lsel = LG_BIC;
         OP_BIS:  lsel = LG_BIS;
         OP_XOR:  begin is_xor = 1'b1; logic_cv = 1'b1; flag_we = 1'b1; end
         OP_AND:  begin lsel = LG_AND; logic_cv = 1'b1; flag_we = 1'b1; end
         default: res_we_o = 1'b0;
      endcase
   end

   // Byte mode masks the operands before either datapath sees them.
   assign src_m = byte_i ? {{UPPER{1'b0}}, src_i[BYTE_W-1:0]} : src_i;
   assign dst_m = byte_i ? {{UPPER{1'b0}}, dst_i[BYTE_W-1:0]} : dst_i;

   alu_arith #(
      .DATA_W     (DATA_W),
      .BYTE_W     (BYTE_W),
      .DECIMAL_EN (DECIMAL_EN)
   ) i_arith (
      .src_i     (src_m),
      .dst_i     (dst_m),
      .byte_i    (byte_i),
      .sub_i     (is_sub),
      .use_cin_i (use_cin),
      .dec_i     (is_dec),
      .carry_i   (carry_i),
      .res_o     (ar_res),
      .c_o       (ar_c),
      .v_o       (ar_v)
   );

   alu_logic #(
      .DATA_W (DATA_W)
   ) i_logic (
      .src_i (src_m),
      .dst_i (dst_m),
      .sel_i (lsel),
      .xor_i (is_xor),
      .res_o (lg_res)
   );

   assign result_o = is_arith ? ar_res : lg_res;

   assign sgn_both = byte_i ? (src_m[BYTE_W-1] & dst_m[BYTE_W-1])
                            : (src_m[DATA_W-1] & dst_m[DATA_W-1]);

   always_comb begin
      f_next.n = byte_i ? result_o[BYTE_W-1] : result_o[DATA_W-1];
      f_next.z = byte_i ? (result_o[BYTE_W-1:0] == '0) : (result_o == '0);
      if (logic_cv) begin
         f_next.c = ~f_next.z;
         f_next.v = is_xor & sgn_both;
      end else begin
         f_next.c = ar_c;
         f_next.v = ar_v;
      end
   end

   alu_flag_reg i_flags (
      .clk  (clk),
      .rst_n(rst_n),
      .we_i (exec_i & flag_we),
      .d_i  (f_next),
      .q_o  (f_q)
   );

   assign flag_c_o = f_q.c;
   assign flag_z_o = f_q.z;
   assign flag_n_o = f_q.n;
   assign flag_v_o = f_q.v;

   AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      byte_i |-> (result_o[DATA_W-1:BYTE_W] == '0)) else $error("byte upper set"); // R6
   AST_NO_WRITE_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode_i == 4'h5 || opcode_i == 4'h7) |-> !res_we_o) else $error("compare wrote"); // R7
   AST_MOVE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && (opcode_i == 4'h0 || opcode_i == 4'h8 || opcode_i == 4'h9))
      |=> $stable({flag_c_o, flag_z_o, flag_n_o, flag_v_o})) else $error("move changed flags"); // R9
   AST_AND_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && (opcode_i == 4'hB || opcode_i == 4'h7)) |=> (!flag_v_o && (flag_c_o != flag_z_o)))
      else $error("and flags wrong"); // R8
   AST_DEC_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && opcode_i == 4'h6) |=> !flag_v_o) else $error("decimal overflow set"); // R10
endmodule

// File: tb/test_alu_flags_unit.sv
module test_alu_flags_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exec_i = 1'b0;
   logic [3:0]  opcode_i = 4'h0;
   logic        byte_i = 1'b0;
   logic        carry_i = 1'b0;
   logic [15:0] src_i = '0;
   logic [15:0] dst_i = '0;
   logic [15:0] result_o;
   logic        res_we_o;
   logic        flag_c_o, flag_z_o, flag_n_o, flag_v_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #10 clk = ~clk;

   alu_flags_unit i_alu_flags_unit (
      .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .opcode_i(opcode_i),
      .byte_i(byte_i), .carry_i(carry_i), .src_i(src_i), .dst_i(dst_i),
      .result_o(result_o), .res_we_o(res_we_o),
      .flag_c_o(flag_c_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o), .flag_v_o(flag_v_o)
   );

   // {op, byte, cin, src, dst, result, we, flags C Z N V}
   localparam int NV = 23;
   localparam logic [58:0] VEC [NV] = '{
      {4'h1, 1'b0, 1'b0, 16'h0001, 16'h7FFF, 16'h8000, 1'b1, 4'b0011}, // R2 R4 R5
      {4'h1, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 4'b1100}, // R2
      {4'h2, 1'b0, 1'b1, 16'h0001, 16'h0002, 16'h0004, 1'b1, 4'b0000}, // R2
      {4'h3, 1'b0, 1'b0, 16'h0001, 16'h0001, 16'h0000, 1'b1, 4'b1100}, // R3
      {4'h3, 1'b0, 1'b0, 16'h0002, 16'h0001, 16'hFFFF, 1'b1, 4'b0010}, // R3
      {4'h3, 1'b0, 1'b0, 16'hFFFF, 16'h7FFF, 16'h8000, 1'b1, 4'b0011}, // R4
      {4'h4, 1'b0, 1'b0, 16'h0001, 16'h0005, 16'h0003, 1'b1, 4'b1000}, // R3
      {4'h5, 1'b0, 1'b0, 16'h0005, 16'h0005, 16'h0000, 1'b0, 4'b1100}, // R7
      {4'h0, 1'b0, 1'b0, 16'h1234, 16'hAAAA, 16'h1234, 1'b1, 4'b1100}, // R1 R9
      {4'hB, 1'b0, 1'b0, 16'hF0F0, 16'h0F0F, 16'h0000, 1'b1, 4'b0100}, // R8
      {4'h7, 1'b0, 1'b0, 16'h8001, 16'h8000, 16'h8000, 1'b0, 4'b1010}, // R8
      {4'h8, 1'b0, 1'b0, 16'h00FF, 16'h1234, 16'h1200, 1'b1, 4'b1010}, // R1 R9
      {4'h9, 1'b0, 1'b0, 16'h000F, 16'h1230, 16'h123F, 1'b1, 4'b1010}, // R1 R9
      {4'hA, 1'b0, 1'b0, 16'h8000, 16'h8001, 16'h0001, 1'b1, 4'b1001}, // R8
      {4'h1, 1'b1, 1'b0, 16'h12FF, 16'h3401, 16'h0000, 1'b1, 4'b1100}, // R6
      {4'h1, 1'b1, 1'b0, 16'hAB50, 16'h0050, 16'h00A0, 1'b1, 4'b0011}, // R6 R4
      {4'h3, 1'b1, 1'b0, 16'h0080, 16'h007F, 16'h00FF, 1'b1, 4'b0011}, // R4
      {4'h6, 1'b0, 1'b0, 16'h0199, 16'h0001, 16'h0200, 1'b1, 4'b0000}, // R10
      {4'h6, 1'b0, 1'b1, 16'h9999, 16'h0000, 16'h0000, 1'b1, 4'b1100}, // R10
      {4'h6, 1'b1, 1'b0, 16'h0045, 16'h1238, 16'h0083, 1'b1, 4'b0010}, // R10 R5
      {4'h6, 1'b1, 1'b0, 16'h0050, 16'h0060, 16'h0010, 1'b1, 4'b1000}, // R10
      {4'h2, 1'b1, 1'b1, 16'h007F, 16'h0000, 16'h0080, 1'b1, 4'b0011}, // R2 R4
      {4'h5, 1'b1, 1'b0, 16'h0001, 16'hFF00, 16'h00FF, 1'b0, 4'b0010}  // R7 R3
   };

   function automatic logic [3:0] flags_now();
      return {flag_c_o, flag_z_o, flag_n_o, flag_v_o};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] op, input logic b, input logic c,
                        input logic [15:0] s, input logic [15:0] d, input logic ex);
      opcode_i = op; byte_i = b; carry_i = c; src_i = s; dst_i = d; exec_i = ex;
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset flags", {28'd0, flags_now()}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][58:55], VEC[i][54], VEC[i][53], VEC[i][52:37], VEC[i][36:21], 1'b1);
         #5;
         check($sformatf("R1-6 vec %0d result", i), {16'd0, result_o}, {16'd0, VEC[i][20:5]});
         check($sformatf("R7 vec %0d we", i), {31'd0, res_we_o}, {31'd0, VEC[i][4]});
         @(negedge clk);
         check($sformatf("R5 vec %0d flags", i), {28'd0, flags_now()}, {28'd0, VEC[i][3:0]});
      end

      // exec low: a flag-writing add must not change flags (flags now 0010)
      drive(4'h1, 1'b0, 1'b0, 16'hFFFF, 16'h0001, 1'b0);
      @(negedge clk);
      check("R11 exec low hold", {28'd0, flags_now()}, 32'b0010);

      // unused code: no write, flags unchanged
      drive(4'hD, 1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1);
      #5;
      check("R7 unused code we", {31'd0, res_we_o}, 32'd0);
      @(negedge clk);
      check("R7 unused code flags", {28'd0, flags_now()}, 32'b0010);

      // byte operand upper bits ignored in AND: low bytes give zero
      drive(4'hB, 1'b1, 1'b0, 16'hFF0F, 16'hFFF0, 1'b1);
      #5;
      check("R6 byte and result", {16'd0, result_o}, 32'h0000);
      @(negedge clk);
      check("R8 byte and flags", {28'd0, flags_now()}, 32'b0100);

      // reset in mid-run clears flags
      drive(4'h1, 1'b0, 1'b0, 16'h0001, 16'h7FFF, 1'b1);
      @(negedge clk);
      exec_i = 1'b0;
      rst_n = 1'b0;
      #5;
      check("R11 async reset", {28'd0, flags_now()}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule